// File: doc/BRIEF.md
# Free-Frame Queue Pop Engine with Read-Ahead

This block hands out free message-frame addresses to a host. The addresses sit in a circular queue in local memory. A head pointer and a tail pointer track the queue, and both hold byte offsets from a programmable base address.

The local processor adds an entry in two steps. It stores a 32-bit frame address in memory at base plus head, then writes the advanced head value through the configuration port. A host read of the pop port removes one entry. It fetches the word at base plus tail, returns it and moves the tail forward by one word. When the queue has nothing in it, the read returns an all-ones word instead.

An optional read-ahead slot can be switched on through a control bit. While it is on, the engine fetches the following entry in advance after each pop, so the next host read can be answered without a memory round trip. The engine reaches local memory through a simple read master that has one read in flight at a time.

Top module: `frame_pool_popper`

## Requirements
- R1: When head equals tail, a host pop returns 0xFFFFFFFF and the tail stays where it is.
- R2: When head differs from tail, a host pop returns the 32-bit word stored at base plus tail and then advances the tail by 4.
- R3: Pointers are byte offsets that wrap to zero at QUEUE_BYTES. A head write keeps only the bits below QUEUE_BYTES, with bits 1:0 forced to zero.
- R4: The configuration readback uses these indices: 0 is the base (bits 1:0 read as zero), 1 is the head, 2 is the tail (read-only), and 3 is control/status. In control/status, bit 3 is the read-ahead enable and bit 0 reads 1 when the queue is empty. After reset the base, head, tail and enable are all zero.
- R5: With read-ahead enabled, a pop that leaves the queue non-empty triggers exactly one memory read of the next entry. The following pop is then answered on the first clock edge after its request.
- R6: With read-ahead disabled, each pop of a non-empty queue makes exactly one memory read, and a pop of an empty queue makes none.
- R7: Clearing the enable bit discards any read-ahead data without moving the tail, and the next pop returns that same entry. A flush also discards read-ahead data.
- R8: Writing 1 to control bit 1 sets head and tail to zero. Bit 1 always reads back as zero.
- R9: A pop that arrives while a read-ahead fetch is in flight waits for that fetch and is answered with its data, with no extra memory read.
- R10: host_rd_ready is a single-cycle pulse. mem_rd_valid stays high with a stable address until mem_rd_ready. At most one memory read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_widx | input | 2 | Configuration write register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_ridx | input | 2 | Configuration readback register index |
| cfg_rdata | output | 32 | Configuration readback data (combinational) |
| host_rd_valid | input | 1 | Host pop request, held until ready |
| host_rd_ready | output | 1 | Pop completion pulse |
| host_rd_data | output | 32 | Popped frame address or 0xFFFFFFFF |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The hardest case to reach is a pop that lands while a read-ahead fetch is still in flight. A close second is a filled read-ahead slot that must be dropped when the enable bit is cleared or the queue is flushed. The bench stretches the memory latency and issues two pops back to back to catch the fetch in flight. It then counts memory reads to confirm that no second read was made. For the discard case, it lets the slot fill, flips the control bit, and checks the tail and the next popped value.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] EMPTY_TOKEN = 32'hFFFF_FFFF;

    // configuration register indices
    localparam logic [1:0] IDX_BASE = 2'd0;
    localparam logic [1:0] IDX_HEAD = 2'd1;
    localparam logic [1:0] IDX_TAIL = 2'd2;
    localparam logic [1:0] IDX_CTRL = 2'd3;

    // control/status bit positions
    localparam int unsigned CTRL_EMPTY_BIT = 0;
    localparam int unsigned CTRL_FLUSH_BIT = 1;
    localparam int unsigned CTRL_PF_BIT    = 3;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_DEM_REQ,
        ENG_DEM_WAIT,
        ENG_PF_REQ,
        ENG_PF_WAIT
    } eng_state_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } pf_slot_t;
endpackage

// File: rtl/fpp_regs.sv
module fpp_regs
    import fpp_pkg::*;
#(
    parameter int unsigned PTR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_widx,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [1:0]        reg_ridx,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tail_adv,
    output logic [WORD_W-1:0] base_q,
    output logic [PTR_W-1:0]  head_q,
    output logic [PTR_W-1:0]  tail_q,
    output logic              pf_en,
    output logic              flush
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(4);

    assign flush = reg_wr && (reg_widx == IDX_CTRL) && reg_wdata[CTRL_FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            head_q <= '0;
            tail_q <= '0;
            pf_en  <= 1'b0;
        end else begin
            if (reg_wr && reg_widx == IDX_BASE)
                base_q <= {reg_wdata[WORD_W-1:2], 2'b00};
            if (reg_wr && reg_widx == IDX_HEAD)
                head_q <= {reg_wdata[PTR_W-1:2], 2'b00};
            if (reg_wr && reg_widx == IDX_CTRL)
                pf_en <= reg_wdata[CTRL_PF_BIT];
            if (tail_adv)
                tail_q <= tail_q + STEP;
            if (flush) begin
                head_q <= '0;
                tail_q <= '0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_ridx)
            IDX_BASE: reg_rdata = base_q;
            IDX_HEAD: reg_rdata = WORD_W'(head_q);
            IDX_TAIL: reg_rdata = WORD_W'(tail_q);
            default: begin
                reg_rdata[CTRL_PF_BIT]    = pf_en;
                reg_rdata[CTRL_EMPTY_BIT] = (head_q == tail_q);
            end
        endcase
    end
endmodule

// File: rtl/fpp_engine.sv
module fpp_engine
    import fpp_pkg::*;
#(
    parameter int unsigned PTR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] base_q,
    input  logic [PTR_W-1:0]  head_q,
    input  logic [PTR_W-1:0]  tail_q,
    input  logic              pf_en,
    input  logic              flush,
    input  logic              host_rd_valid,
    output logic              host_rd_ready,
    output logic [WORD_W-1:0] host_rd_data,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              tail_adv
);
    eng_state_e        st_q;
    pf_slot_t          slot_q;
    logic              stale_q;
    logic              rdy_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] addr_q;

    logic              pop_now;
    logic              sentinel_now;
    logic [WORD_W-1:0] pop_word;

    wire [PTR_W-1:0] tail_nx   = tail_q + PTR_W'(4);
    wire             q_empty   = (head_q == tail_q);
    wire             more_left = (head_q != tail_nx);
    wire             host_pend = host_rd_valid && !rdy_q;
    wire             rsp_live  = mem_rsp_valid && !stale_q && !flush;
    wire             chain_pf  = pf_en && more_left;
    wire [WORD_W-1:0] nx_addr  = base_q + WORD_W'(tail_nx);
    wire [WORD_W-1:0] cur_addr = base_q + WORD_W'(tail_q);

    always_comb begin
        pop_now      = 1'b0;
        sentinel_now = 1'b0;
        pop_word     = EMPTY_TOKEN;
        unique case (st_q)
            ENG_IDLE: if (host_pend && !flush) begin
                if (q_empty) begin
                    sentinel_now = 1'b1;
                end else if (slot_q.valid && pf_en) begin
                    pop_now  = 1'b1;
                    pop_word = slot_q.word;
                end
            end
            ENG_DEM_WAIT: if (rsp_live) begin
                pop_now  = 1'b1;
                pop_word = mem_rsp_data;
            end
            ENG_PF_WAIT: if (rsp_live && host_pend) begin
                pop_now  = 1'b1;
                pop_word = mem_rsp_data;
            end
            default: ;
        endcase
    end

    assign tail_adv      = pop_now;
    assign host_rd_ready = rdy_q;
    assign host_rd_data  = rdata_q;
    assign mem_rd_valid  = (st_q == ENG_DEM_REQ) || (st_q == ENG_PF_REQ);
    assign mem_rd_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ENG_IDLE;
            slot_q  <= '0;
            stale_q <= 1'b0;
            rdy_q   <= 1'b0;
            rdata_q <= '0;
            addr_q  <= '0;
        end else begin
            rdy_q <= 1'b0;
            if (flush || !pf_en)
                slot_q.valid <= 1'b0;
            if ((flush || !pf_en) && (st_q == ENG_PF_REQ || st_q == ENG_PF_WAIT))
                stale_q <= 1'b1;
            if (flush && (st_q == ENG_DEM_REQ || st_q == ENG_DEM_WAIT))
                stale_q <= 1'b1;
            if (sentinel_now || pop_now) begin
                rdy_q   <= 1'b1;
                rdata_q <= pop_word;
            end
            unique case (st_q)
                ENG_IDLE: if (host_pend && !flush && !q_empty) begin
                    if (pop_now) begin
                        slot_q.valid <= 1'b0;
                        if (chain_pf) begin
                            addr_q <= nx_addr;
                            st_q   <= ENG_PF_REQ;
                        end
                    end else begin
                        addr_q <= cur_addr;
                        st_q   <= ENG_DEM_REQ;
                    end
                end
                ENG_DEM_REQ: if (mem_rd_ready) st_q <= ENG_DEM_WAIT;
                ENG_PF_REQ:  if (mem_rd_ready) st_q <= ENG_PF_WAIT;
                ENG_DEM_WAIT, ENG_PF_WAIT: if (mem_rsp_valid) begin
                    stale_q <= 1'b0;
                    st_q    <= ENG_IDLE;
                    if (pop_now) begin
                        if (chain_pf) begin
                            addr_q <= nx_addr;
                            st_q   <= ENG_PF_REQ;
                        end
                    end else if (st_q == ENG_PF_WAIT && rsp_live && pf_en) begin
                        slot_q <= '{valid: 1'b1, word: mem_rsp_data};
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame_pool_popper.sv
module frame_pool_popper
    import fpp_pkg::*;
#(
    parameter int unsigned QUEUE_BYTES = 16384
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_widx,
    input  logic [31:0] cfg_wdata,
    input  logic [1:0]  cfg_ridx,
    output logic [31:0] cfg_rdata,
    input  logic        host_rd_valid,
    output logic        host_rd_ready,
    output logic [31:0] host_rd_data,
    output logic        mem_rd_valid,
    input  logic        mem_rd_ready,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    localparam int unsigned PTR_W = $clog2(QUEUE_BYTES);

    logic [WORD_W-1:0] base_q;
    logic [PTR_W-1:0]  head_q;
    logic [PTR_W-1:0]  tail_q;
    logic              pf_en;
    logic              flush;
    logic              tail_adv;

    fpp_regs #(.PTR_W(PTR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (cfg_wr),
        .reg_widx (cfg_widx),
        .reg_wdata(cfg_wdata),
        .reg_ridx (cfg_ridx),
        .reg_rdata(cfg_rdata),
        .tail_adv (tail_adv),
        .base_q   (base_q),
        .head_q   (head_q),
        .tail_q   (tail_q),
        .pf_en    (pf_en),
        .flush    (flush)
    );

    fpp_engine #(.PTR_W(PTR_W)) u_eng (
        .clk          (clk),
        .rst          (rst),
        .base_q       (base_q),
        .head_q       (head_q),
        .tail_q       (tail_q),
        .pf_en        (pf_en),
        .flush        (flush),
        .host_rd_valid(host_rd_valid),
        .host_rd_ready(host_rd_ready),
        .host_rd_data (host_rd_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .tail_adv     (tail_adv)
    );
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int unsigned PTR_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rd_ready,
    input logic [31:0]      host_rd_data,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [31:0]      mem_rd_addr,
    input logic             mem_rsp_valid,
    input logic [PTR_W-1:0] tail_q
);
    logic [1:0] inflight;
    wire        accept = mem_rd_valid && mem_rd_ready;

    always_ff @(posedge clk) begin
        if (rst) inflight <= '0;
        else     inflight <= 2'(inflight + {1'b0, accept} - {1'b0, mem_rsp_valid});
    end

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        host_rd_ready |=> !host_rd_ready);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_single_read_r10: assert property (@(posedge clk) disable iff (rst)
        accept |-> (inflight == 2'd0));

    p_sentinel_r1: assert property (@(posedge clk) disable iff (rst)
        (host_rd_ready && $stable(tail_q)) |-> (host_rd_data == 32'hFFFF_FFFF));

    p_tail_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(tail_q) |-> (tail_q == PTR_W'($past(tail_q) + PTR_W'(4)) || tail_q == '0));
endmodule

bind frame_pool_popper fpp_checker #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd_ready(host_rd_ready),
    .host_rd_data (host_rd_data),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .tail_q       (tail_q)
);

// File: tb/tb_frame_pool_popper.sv
module tb_frame_pool_popper;
    localparam int QB    = 256;
    localparam int SLOTS = QB / 4;
    localparam logic [31:0] QBASE = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_widx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic        host_rd_valid = 1'b0;
    logic        host_rd_ready;
    logic [31:0] host_rd_data;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #2 clk = ~clk;

    frame_pool_popper #(.QUEUE_BYTES(QB)) dut (.*);

    logic [31:0] qmem [SLOTS];
    int exp_head = 0, exp_tail = 0;
    int checks = 0, fails = 0;
    int mem_lat = 0;
    int rd_count = 0;
    logic        pend;
    int          cnt;
    logic [31:0] paddr;

    // memory model: random accept, programmable latency
    always @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0; cnt <= 0; paddr <= '0;
            mem_rsp_valid <= 1'b0; mem_rsp_data <= '0; mem_rd_ready <= 1'b0;
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rd_ready  <= ($urandom % 4) != 0;
            if (mem_rd_valid && mem_rd_ready) begin
                pend <= 1'b1; cnt <= mem_lat; paddr <= mem_rd_addr;
                rd_count <= rd_count + 1;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= qmem[((paddr - QBASE) >> 2) % SLOTS];
                    pend <= 1'b0;
                end else cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_widx = idx; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] idx, output logic [31:0] v);
        @(negedge clk); cfg_ridx = idx; #1 v = cfg_rdata;
    endtask

    task automatic push(input logic [31:0] val);
        qmem[exp_head / 4] = val;
        exp_head = (exp_head + 4) % QB;
        cfg_write(2'd1, exp_head);
    endtask

    task automatic pop(output logic [31:0] d, output int lat);
        @(negedge clk); host_rd_valid = 1'b1; lat = 0; d = '0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1; lat++;
            if (host_rd_ready) begin d = host_rd_data; break; end
        end
        host_rd_valid = 1'b0;
    endtask

    function automatic logic [31:0] model_pop();
        logic [31:0] e;
        if (exp_head == exp_tail) return 32'hFFFF_FFFF;
        e = qmem[exp_tail / 4];
        exp_tail = (exp_tail + 4) % QB;
        return e;
    endfunction

    task automatic pop_check(input string tag, output int lat);
        logic [31:0] d, e, t;
        e = model_pop();
        pop(d, lat);
        check(d === e, tag, d, e);
        cfg_read(2'd2, t);
        check(t == exp_tail, {tag, " tail"}, t, exp_tail);
    endtask

    task automatic flush_q();
        cfg_write(2'd3, 32'h2);
        exp_head = 0; exp_tail = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, d;
        int lat, c0, pending;
        void'($urandom(32'd7391));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R4 reset state
        cfg_read(2'd0, v); check(v == 0, "R4 base reset", v, 0);
        cfg_read(2'd1, v); check(v == 0, "R4 head reset", v, 0);
        cfg_read(2'd2, v); check(v == 0, "R4 tail reset", v, 0);
        cfg_read(2'd3, v); check(v == 1, "R4 ctrl reset", v, 1);
        check(!mem_rd_valid && !host_rd_ready, "R4 idle outputs", {mem_rd_valid, host_rd_ready}, 0);
        cfg_write(2'd0, QBASE | 32'h3);
        cfg_read(2'd0, v); check(v == QBASE, "R4 base aligned", v, QBASE);

        // R1 / R6 empty pop
        c0 = rd_count;
        pop_check("R1 empty sentinel", lat);
        check(rd_count == c0, "R6 no read on empty", rd_count, c0);

        // R2 / R6 plain pops
        for (int i = 0; i < 5; i++) push($urandom);
        c0 = rd_count;
        for (int i = 0; i < 3; i++) pop_check("R2 plain pop", lat);
        repeat (10) @(posedge clk);
        check(rd_count == c0 + 3, "R6 one read per pop", rd_count, c0 + 3);

        // R8 flush, R3 head mask
        flush_q();
        cfg_read(2'd1, v); check(v == 0, "R8 head cleared", v, 0);
        cfg_read(2'd2, v); check(v == 0, "R8 tail cleared", v, 0);
        cfg_read(2'd3, v); check(v[1] == 0, "R8 flush bit reads 0", v, 0);
        pop_check("R8 empty after flush", lat);
        cfg_write(2'd1, 32'h0000_0106);
        cfg_read(2'd1, v); check(v == 32'h4, "R3 head masked", v, 32'h4);
        flush_q();

        // R3 wrap, random traffic with prefetch off
        pending = 0;
        for (int i = 0; i < 300; i++) begin
            if (pending < 40 && ($urandom % 2)) begin push($urandom); pending++; end
            else begin pop_check("R3 R2 random wrap", lat); if (pending > 0) pending--; end
        end

        // R5 prefetch
        flush_q();
        cfg_write(2'd3, 32'h8);
        cfg_read(2'd3, v); check(v == 32'h9, "R4 ctrl pf readback", v, 32'h9);
        for (int i = 0; i < 4; i++) push($urandom);
        c0 = rd_count;
        pop_check("R5 first pop", lat);
        repeat (20) @(posedge clk);
        check(rd_count == c0 + 2, "R5 one read-ahead", rd_count, c0 + 2);
        pop_check("R5 pop from slot", lat);
        check(lat == 1, "R5 slot latency", lat, 1);
        repeat (20) @(posedge clk);

        // R7 disable discards slot
        cfg_write(2'd3, 32'h0);
        cfg_read(2'd2, v); check(v == exp_tail, "R7 tail kept", v, exp_tail);
        pop_check("R7 same entry after discard", lat);
        check(lat > 1, "R7 demand after discard", lat, 2);

        // R7 flush discards slot
        cfg_write(2'd3, 32'h8);
        for (int i = 0; i < 3; i++) push($urandom);
        pop_check("R7 pre-flush pop", lat);
        repeat (20) @(posedge clk);
        cfg_write(2'd3, 32'hA); exp_head = 0; exp_tail = 0;
        push(32'hCAFE_0001);
        pop_check("R7 flush drops slot", lat);

        // R9 pop during outstanding read-ahead
        mem_lat = 8;
        flush_q(); cfg_write(2'd3, 32'h8);
        for (int i = 0; i < 3; i++) push($urandom);
        c0 = rd_count;
        pop_check("R9 first", lat);
        e_pop_r9: begin
            logic [31:0] e;
            e = model_pop();
            pop(d, lat);
            check(d === e, "R9 answered by in-flight read", d, e);
        end
        repeat (30) @(posedge clk);
        check(rd_count == c0 + 3, "R9 no extra read", rd_count, c0 + 3);

        // mixed random with prefetch toggling
        flush_q(); pending = 0;
        for (int i = 0; i < 400; i++) begin
            mem_lat = $urandom % 4;
            if (($urandom % 16) == 0) cfg_write(2'd3, ($urandom % 2) ? 32'h8 : 32'h0);
            if (pending < 40 && ($urandom % 2)) begin push($urandom); pending++; end
            else begin pop_check("R2 R5 R7 mixed", lat); if (pending > 0) pending--; end
            if (($urandom % 4) == 0) repeat ($urandom % 12) @(posedge clk);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule